// File: doc/BRIEF.md
# SCSI Block-Move Transfer Sequencer

This block carries out a single block-move command on a parallel SCSI bus. A 32-bit command word gives the bus phase wanted and the number of bytes to move. The block works byte by byte. Each byte passes between the bus data lines and a byte-wide stream on the memory side. The block can act as initiator or as target.

As initiator, the block first compares the wanted phase with the phase it latched on the last REQ rise. If they differ, it raises a mismatch pulse and moves nothing. If they agree, it runs one REQ/ACK handshake for each byte. Two phases change the final handshake. In message-out, ATN drops as the final ACK is raised. In message-in, ACK stays asserted after the final byte until a clear-ACK pulse arrives. As target, the block drives the wanted phase onto the MSG, C/D and I/O lines, raises REQ for each byte and waits for the initiator's ACK.

A byte counter is loaded from the command and decremented as each handshake closes. It reads zero after a complete move. It keeps the remaining count if the bus phase changes part way through a move.

Top module: `scsi_move_seq`

## Requirements
- R1: On an accepted start, `count_o` loads command bits [23:0] and the wanted phase is taken from bits [26:24]. `count_o` drops by exactly one per completed handshake and reads 0 when `done_o` pulses after a full move.
- R2: A start with a byte count of 0 produces a one-cycle `done_o` pulse with no handshake: ACK and REQ stay low.
- R3: In initiator mode, a start whose phase differs from the phase latched on the most recent rise of `req_in` produces a one-cycle `mismatch_o` pulse, raises no ACK and leaves `count_o` at the loaded value. `done_o` and `mismatch_o` are never high together.
- R4: Initiator handshake order: ACK rises only after `req_in` has been seen high, and ACK falls only after `req_in` has been seen low.
- R5: Phases are encoded as {MSG, C/D, I/O}: 000 data-out, 001 data-in, 010 command, 011 status, 100/101 reserved out/in, 110 message-out, 111 message-in. As initiator, odd codes pass each bus byte to `mem_wr_data` with a `mem_wr_valid` pulse. Even codes take bytes from the memory stream and drive them on the bus with `bus_data_oe` high. The bus is driven in no other case.
- R6: In message-out (110), `atn_out` (set by `set_atn`) stays high through every handshake but the last. It is low once the final ACK is raised.
- R7: In message-in (111), ACK stays high after the final byte's REQ falls and after `done_o`. It falls one cycle after a `clr_ack` pulse.
- R8: If `bus_phase_in` at a REQ assertion differs from the wanted phase during a move, the block pulses `mismatch_o`, raises no ACK for that byte, returns idle and keeps the remaining count in `count_o`.
- R9: In target mode, `phase_oe` is high and `phase_out` equals the wanted phase while busy. `req_out` is raised for each byte and released after `ack_in` is seen. Direction is mirrored: odd codes send memory bytes onto the bus, and even codes pass bus bytes to memory.
- R10: A start pulse while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the move given by `instr` |
| instr | input | 32 | Command word: [26:24] phase, [23:0] count |
| target_mode | input | 1 | 1 = act as target, 0 = initiator |
| set_atn | input | 1 | Pulse: assert ATN |
| clr_ack | input | 1 | Pulse: release a held ACK while idle |
| bus_phase_in | input | 3 | {MSG,C/D,I/O} seen on the bus |
| req_in | input | 1 | REQ from target (initiator mode) |
| ack_in | input | 1 | ACK from initiator (target mode) |
| bus_data_in | input | 8 | Bus data lines in |
| bus_data_out | output | 8 | Bus data lines out |
| bus_data_oe | output | 1 | Drive enable for bus data |
| ack_out | output | 1 | ACK to target |
| atn_out | output | 1 | ATN to target |
| req_out | output | 1 | REQ to initiator (target mode) |
| phase_out | output | 3 | Phase driven in target mode |
| phase_oe | output | 1 | Drive enable for phase lines |
| mem_rd_data | input | 8 | Byte from memory stream |
| mem_rd_valid | input | 1 | Memory byte available |
| mem_rd_ready | output | 1 | Block takes a memory byte |
| mem_wr_data | output | 8 | Byte to memory stream |
| mem_wr_valid | output | 1 | One-cycle write strobe |
| count_o | output | 24 | Remaining byte count |
| busy | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | One-cycle phase-mismatch pulse |

## Verification
The bench sweeps all eight phase codes with counts 0 to 3 as initiator and counts 1 to 2 as target. It acts as the bus partner for every byte. It predicts each bus and memory byte from a running index, so a design that inverts the direction for any code drives the bus in the wrong phase or writes the wrong bytes. The message phases are probed at the last byte. A design that drops ATN one byte early or late would show a wrong `atn_out` when ACK rises. A design that releases ACK at the end of message-in, or ignores `clr_ack`, would fail the hold checks. Dedicated runs cover three more cases: a start against a stale latched phase, a phase change after the first byte (the count must read 2, not 3 or 0), and a second start issued mid-move that must not reload the counter.

// File: rtl/scsi_move_seq.sv
module scsi_move_seq #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      instr,
  input  logic             target_mode,
  input  logic             set_atn,
  input  logic             clr_ack,
  input  logic [2:0]       bus_phase_in,
  input  logic             req_in,
  input  logic             ack_in,
  input  logic [7:0]       bus_data_in,
  output logic [7:0]       bus_data_out,
  output logic             bus_data_oe,
  output logic             ack_out,
  output logic             atn_out,
  output logic             req_out,
  output logic [2:0]       phase_out,
  output logic             phase_oe,
  input  logic [7:0]       mem_rd_data,
  input  logic             mem_rd_valid,
  output logic             mem_rd_ready,
  output logic [7:0]       mem_wr_data,
  output logic             mem_wr_valid,
  output logic [CNT_W-1:0] count_o,
  output logic             busy,
  output logic             done_o,
  output logic             mismatch_o
);
  localparam logic [2:0] PH_MSG_OUT = 3'b110;
  localparam logic [2:0] PH_MSG_IN  = 3'b111;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_IREQ, S_IACK, S_IREL, S_TREQ, S_TREL} st_t;

  st_t              st;
  logic [2:0]       ph, lat_ph;
  logic             tgt, req_d;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       dout;

  wire [2:0]       new_ph  = instr[26:24];
  wire [CNT_W-1:0] new_cnt = instr[CNT_W-1:0];
  wire             unused_bits = &{1'b0, instr[31:27]};
  wire             send  = tgt ? ph[0] : ~ph[0];
  wire             last  = (cnt == CNT_W'(1));

  assign busy         = (st != S_IDLE);
  assign count_o      = cnt;
  assign phase_out    = ph;
  assign phase_oe     = tgt && busy;
  assign req_out      = (st == S_TREQ);
  assign mem_rd_ready = (st == S_FETCH);
  assign bus_data_out = dout;
  assign bus_data_oe  = send && (tgt ? (st == S_TREQ || st == S_TREL)
                                     : (st == S_IACK || st == S_IREL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ph           <= '0;
      lat_ph       <= '0;
      tgt          <= 1'b0;
      req_d        <= 1'b0;
      cnt          <= '0;
      dout         <= '0;
      mem_wr_data  <= '0;
      mem_wr_valid <= 1'b0;
      ack_out      <= 1'b0;
      atn_out      <= 1'b0;
      done_o       <= 1'b0;
      mismatch_o   <= 1'b0;
    end else begin
      done_o       <= 1'b0;
      mismatch_o   <= 1'b0;
      mem_wr_valid <= 1'b0;
      req_d        <= req_in;
      if (req_in && !req_d) lat_ph <= bus_phase_in;
      if (set_atn) atn_out <= 1'b1;
      unique case (st)
        S_IDLE: begin
          if (clr_ack) ack_out <= 1'b0;
          if (start) begin
            ph  <= new_ph;
            tgt <= target_mode;
            cnt <= new_cnt;
            if (new_cnt == '0)                             done_o     <= 1'b1;
            else if (!target_mode && new_ph != lat_ph)     mismatch_o <= 1'b1;
            else if (target_mode)                          st <= new_ph[0] ? S_FETCH : S_TREQ;
            else                                           st <= S_IREQ;
          end
        end
        S_IREQ: begin
          if (req_in) begin
            if (bus_phase_in != ph) begin
              mismatch_o <= 1'b1;
              st         <= S_IDLE;
            end else if (send) begin
              st <= S_FETCH;
            end else begin
              mem_wr_data  <= bus_data_in;
              mem_wr_valid <= 1'b1;
              st           <= S_IACK;
            end
          end
        end
        S_FETCH: begin
          if (mem_rd_valid) begin
            dout <= mem_rd_data;
            st   <= tgt ? S_TREQ : S_IACK;
          end
        end
        S_IACK: begin
          ack_out <= 1'b1;
          if (last && ph == PH_MSG_OUT) atn_out <= 1'b0;
          st <= S_IREL;
        end
        S_IREL: begin
          if (!req_in) begin
            cnt <= cnt - 1'b1;
            if (!(last && ph == PH_MSG_IN)) ack_out <= 1'b0;
            if (last) begin
              done_o <= 1'b1;
              st     <= S_IDLE;
            end else begin
              st <= S_IREQ;
            end
          end
        end
        S_TREQ: begin
          if (ack_in) begin
            if (!send) begin
              mem_wr_data  <= bus_data_in;
              mem_wr_valid <= 1'b1;
            end
            st <= S_TREL;
          end
        end
        S_TREL: begin
          if (!ack_in) begin
            cnt <= cnt - 1'b1;
            if (last) begin
              done_o <= 1'b1;
              st     <= S_IDLE;
            end else begin
              st <= send ? S_FETCH : S_TREQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_mis_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && mismatch_o));
  assert_mis_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_o |-> !busy && !ack_out);
  assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_out) |-> $past(req_in));
  assert_ack_drop_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_out) && !$past(clr_ack)) |-> !$past(req_in));
  assert_atn_drop_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(atn_out) |-> (ack_out && phase_out == PH_MSG_OUT));
  assert_drive_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (phase_oe ? phase_out[0] : !phase_out[0]));
  assert_treq_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> phase_oe);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && count_o != $past(count_o)) |-> count_o == $past(count_o) - 1'b1);
endmodule

// File: tb/scsi_move_seq_bench.sv
module scsi_move_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0, target_mode = 0, set_atn = 0, clr_ack = 0;
  logic [31:0] instr = '0;
  logic [2:0] bus_phase = '0;
  logic req_in = 0, ack_in = 0;
  logic [7:0] bus_data_in = '0;
  logic [7:0] bus_data_out, mem_wr_data;
  logic bus_data_oe, ack_out, atn_out, req_out, phase_oe, mem_rd_ready, mem_wr_valid;
  logic busy, done_o, mismatch_o;
  logic [2:0] phase_out;
  logic [23:0] count_o;
  logic [7:0] rd_idx = 0;
  int wr_cnt = 0, done_cnt = 0, mis_cnt = 0;
  logic [7:0] wlog [0:255];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_move_seq u_scsi_move_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .target_mode(target_mode),
    .set_atn(set_atn), .clr_ack(clr_ack), .bus_phase_in(bus_phase), .req_in(req_in),
    .ack_in(ack_in), .bus_data_in(bus_data_in), .bus_data_out(bus_data_out),
    .bus_data_oe(bus_data_oe), .ack_out(ack_out), .atn_out(atn_out), .req_out(req_out),
    .phase_out(phase_out), .phase_oe(phase_oe), .mem_rd_data(8'h50 + rd_idx),
    .mem_rd_valid(1'b1), .mem_rd_ready(mem_rd_ready), .mem_wr_data(mem_wr_data),
    .mem_wr_valid(mem_wr_valid), .count_o(count_o), .busy(busy), .done_o(done_o),
    .mismatch_o(mismatch_o));

  always @(posedge clk) begin
    if (mem_rd_ready) rd_idx <= rd_idx + 1'b1;
    if (mem_wr_valid) begin wlog[wr_cnt % 256] <= mem_wr_data; wr_cnt <= wr_cnt + 1; end
    if (done_o) done_cnt <= done_cnt + 1;
    if (mismatch_o) mis_cnt <= mis_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input [2:0] p, input int n, input bit tm);
    target_mode = tm;
    instr = {5'b0, p, 24'(n)};
    start = 1; tick(1); start = 0;
  endtask

  task automatic latch_phase(input [2:0] p);
    bus_phase = p; req_in = 1; tick(1); req_in = 0; tick(1);
  endtask

  task automatic init_move(input [2:0] p, input int n);
    int rb, wb, dn, ms;
    latch_phase(p);
    if (p == 3'b110) begin set_atn = 1; tick(1); set_atn = 0; end
    rb = rd_idx; wb = wr_cnt; dn = done_cnt; ms = mis_cnt;
    issue(p, n, 0);
    if (n == 0) begin
      tick(1);
      check(done_cnt == dn + 1, "R2 zero-count done", done_cnt - dn, 1);
      check(!ack_out && !busy, "R2 no handshake", {ack_out, busy}, 0);
      if (p == 3'b110) check(atn_out == 1, "R6 atn kept on empty move", atn_out, 1);
      return;
    end
    check(count_o == 24'(n), "R1 count load", count_o, n);
    for (int k = 0; k < n; k++) begin
      bus_data_in = 8'hA0 + 8'(k);
      req_in = 1;
      for (int i = 0; i < 10 && !ack_out; i++) tick(1);
      check(ack_out == 1, "R4 ack after req", ack_out, 1);
      if (!p[0]) check(bus_data_oe && bus_data_out == 8'(8'h50 + rb + k), "R5 out byte",
                       {bus_data_oe, bus_data_out}, {1'b1, 8'(8'h50 + rb + k)});
      else check(!bus_data_oe, "R5 no drive in input phase", bus_data_oe, 0);
      if (p == 3'b110) check(atn_out == (k != n - 1), "R6 atn at ack", atn_out, k != n - 1);
      tick(2);
      check(ack_out == 1, "R4 ack held while req high", ack_out, 1);
      req_in = 0;
      if (k == n - 1 && p == 3'b111) begin
        tick(4);
        check(ack_out == 1, "R7 ack held after last msg-in", ack_out, 1);
      end else begin
        for (int i = 0; i < 10 && ack_out; i++) tick(1);
        check(ack_out == 0, "R4 ack released", ack_out, 0);
      end
    end
    tick(2);
    check(done_cnt == dn + 1 && mis_cnt == ms, "R1 done once", done_cnt - dn, 1);
    check(count_o == 0, "R1 count zero", count_o, 0);
    if (p[0]) begin
      check(wr_cnt == wb + n, "R5 write count", wr_cnt - wb, n);
      for (int k = 0; k < n; k++)
        check(wlog[(wb + k) % 256] == 8'hA0 + 8'(k), "R5 in byte", wlog[(wb + k) % 256], 8'hA0 + 8'(k));
    end else begin
      check(8'(rd_idx - 8'(rb)) == 8'(n), "R5 read count", rd_idx - rb, n);
    end
    if (p == 3'b111) begin
      clr_ack = 1; tick(1); clr_ack = 0;
      check(ack_out == 0, "R7 clr_ack releases", ack_out, 0);
    end
  endtask

  task automatic tgt_move(input [2:0] p, input int n);
    int rb, wb, dn;
    rb = rd_idx; wb = wr_cnt; dn = done_cnt;
    issue(p, n, 1);
    check(count_o == 24'(n), "R1 target count load", count_o, n);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 10 && !req_out; i++) tick(1);
      check(req_out == 1, "R9 req raised", req_out, 1);
      check(phase_oe && phase_out == p, "R9 phase driven", {phase_oe, phase_out}, {1'b1, p});
      if (p[0]) check(bus_data_oe && bus_data_out == 8'(8'h50 + rb + k), "R9 target send byte",
                      {bus_data_oe, bus_data_out}, {1'b1, 8'(8'h50 + rb + k)});
      else begin
        check(!bus_data_oe, "R9 target no drive", bus_data_oe, 0);
        bus_data_in = 8'hC0 + 8'(k);
      end
      ack_in = 1;
      for (int i = 0; i < 10 && req_out; i++) tick(1);
      check(req_out == 0, "R9 req released", req_out, 0);
      ack_in = 0; tick(1);
    end
    tick(3);
    check(done_cnt == dn + 1 && count_o == 0 && !phase_oe, "R9 target done",
          {done_cnt - dn, count_o}, 1 << 24);
    if (!p[0]) for (int k = 0; k < n; k++)
      check(wlog[(wb + k) % 256] == 8'hC0 + 8'(k), "R9 target recv byte", wlog[(wb + k) % 256], 8'hC0 + 8'(k));
    target_mode = 0;
  endtask

  initial begin
    tick(2);
    check(!busy && !ack_out && !atn_out && !req_out && !phase_oe && !bus_data_oe,
          "R1 reset state", {busy, ack_out, atn_out, req_out, phase_oe, bus_data_oe}, 0);
    rst_n = 1; tick(1);

    for (int p = 0; p < 8; p++)
      for (int n = 0; n < 4; n++) init_move(3'(p), n);
    for (int p = 0; p < 8; p++)
      for (int n = 1; n < 3; n++) tgt_move(3'(p), n);

    begin : start_mismatch
      int ms;
      latch_phase(3'b010);
      ms = mis_cnt;
      issue(3'b011, 4, 0);
      tick(3);
      check(mis_cnt == ms + 1, "R3 start mismatch", mis_cnt - ms, 1);
      check(!busy && !ack_out && count_o == 4, "R3 nothing moved", {busy, ack_out, count_o}, 4);
    end

    begin : mid_change
      int ms;
      latch_phase(3'b001);
      ms = mis_cnt;
      issue(3'b001, 3, 0);
      req_in = 1;
      for (int i = 0; i < 10 && !ack_out; i++) tick(1);
      req_in = 0;
      for (int i = 0; i < 10 && ack_out; i++) tick(1);
      bus_phase = 3'b011; req_in = 1; tick(3);
      check(mis_cnt == ms + 1, "R8 mid-move mismatch", mis_cnt - ms, 1);
      check(count_o == 2 && !ack_out && !busy, "R8 remaining count", count_o, 2);
      req_in = 0; tick(1);
    end

    begin : busy_start
      int dn;
      latch_phase(3'b001);
      dn = done_cnt;
      issue(3'b001, 2, 0);
      issue(3'b000, 5, 0);
      check(count_o == 2, "R10 restart ignored", count_o, 2);
      for (int k = 0; k < 2; k++) begin
        req_in = 1;
        for (int i = 0; i < 10 && !ack_out; i++) tick(1);
        req_in = 0;
        for (int i = 0; i < 10 && ack_out; i++) tick(1);
      end
      tick(2);
      check(done_cnt == dn + 1 && count_o == 0, "R10 first move finished", count_o, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule